// File: doc/BRIEF.md
# Serial Command Decoder for a Waveform Synthesizer

This block listens on one asynchronous serial line and turns single ASCII characters into the control settings of a small tone generator. It recovers each 8N1 character with a bit-timing counter driven from the system clock. It then looks the character up in a fixed command map and updates one of three registers: a waveform selector, a pitch index and a noise gate.

Characters that are not in the map are received but change nothing. Every recognised command raises a single-cycle strobe, so that downstream logic can restart a phase accumulator or an envelope when a setting is written. The bit period is set by a parameter that gives the number of system clocks per bit. The default of 65 suits a 25 MHz clock at roughly 384 kbaud.

Top module: `synth_cmd_uart`

## Requirements
- R1: While reset is asserted and directly after it, the waveform selector reads 2'b00 (square), the pitch index reads 0, the noise gate reads 0 and the strobe is low.
- R2: A character is framed as one low start bit, eight data bits least significant first, and one high stop bit. Each bit lasts CLKS_PER_BIT clocks and is sampled once near its middle, after a two-flop synchronizer.
- R3: A start bit is accepted only if the line is still low half a bit period after its falling edge. A shorter low pulse changes no output and starts no character.
- R4: Character 0x54 sets the waveform selector to 2'b01 (triangle). 0x53 sets it to 2'b10 (sawtooth), 0x51 to 2'b00 (square) and 0x57 to 2'b11 (sine). The pitch index and the noise gate are left as they are.
- R5: Characters 0x30 to 0x39 load the pitch index with the character value minus 0x30, which gives 0 to 9. The other settings are left as they are.
- R6: Character 0x4E sets the noise gate to 1 and 0x46 clears it. The waveform selector and the pitch index keep their values.
- R7: Any other character value changes no setting and produces no strobe.
- R8: A character whose stop bit samples low is discarded: no setting changes and no strobe is produced. The receiver then waits for the line to return high before it looks for a new start bit.
- R9: Each recognised command produces exactly one strobe cycle, even when the written value equals the old one. The strobe is high in the first cycle in which the new value is visible. No setting ever changes without the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| rx_i | input | 1 | Asynchronous serial input, idles high |
| wave_sel_o | output | 2 | Waveform: 00 square, 01 triangle, 10 sawtooth, 11 sine |
| freq_idx_o | output | 4 | Pitch index 0 to 9 |
| noise_en_o | output | 1 | Noise gate |
| cmd_stb_o | output | 1 | One-cycle pulse on each recognised command |

## Verification
A wrong bit counter or shift order in the receiver shows up one character later. The decoded setting is then wrong for the character sent, or it moves without a strobe, or it does not move at all. A sweep over all 256 character values exposes every misplaced map entry within the frame in which that value is sent. The test checks each setting and the strobe count about three bit periods after each stop bit. Faults in start qualification and framing recovery show up as settings that change after a glitch or after a frame with a low stop bit, where none should change.

// File: rtl/synth_cmd_pkg.sv
package synth_cmd_pkg;

  typedef enum logic [1:0] {
    WAVE_SQUARE = 2'b00,
    WAVE_TRI    = 2'b01,
    WAVE_SAW    = 2'b10,
    WAVE_SINE   = 2'b11
  } wave_e;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_BREAK
  } rx_state_e;

  localparam logic [7:0] CH_TRI    = 8'h54;
  localparam logic [7:0] CH_SAW    = 8'h53;
  localparam logic [7:0] CH_SQUARE = 8'h51;
  localparam logic [7:0] CH_SINE   = 8'h57;
  localparam logic [7:0] CH_NOISE1 = 8'h4E;
  localparam logic [7:0] CH_NOISE0 = 8'h46;
  localparam logic [7:0] CH_DIG_LO = 8'h30;
  localparam logic [7:0] CH_DIG_HI = 8'h39;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d_i;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import synth_cmd_pkg::*;
#(
  parameter int CLKS_PER_BIT = 65,
  parameter int DATA_BITS    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_i,
  output logic                 byte_vld_o,
  output logic [DATA_BITS-1:0] byte_o
);

  localparam int CW   = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int BW   = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam int HALF = CLKS_PER_BIT / 2;
  localparam logic [CW-1:0] CNT_FULL = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] CNT_HALF = CW'(HALF - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(DATA_BITS - 1);

  rx_state_e             state_q, state_d;
  logic [CW-1:0]         cnt_q, cnt_d;
  logic [BW-1:0]         bit_q, bit_d;
  logic [DATA_BITS-1:0]  sr_q;
  logic                  sr_en;
  logic                  vld_q, vld_d;
  logic                  full_tick;
  logic                  half_tick;

  assign full_tick = (cnt_q == CNT_FULL);
  assign half_tick = (cnt_q == CNT_HALF);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    sr_en   = 1'b0;
    vld_d   = 1'b0;
    unique case (state_q)
      RX_IDLE: begin
        cnt_d = '0;
        if (!rx_i) state_d = RX_START;
      end
      RX_START: begin
        if (half_tick) begin
          cnt_d   = '0;
          bit_d   = '0;
          state_d = rx_i ? RX_IDLE : RX_DATA;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      RX_DATA: begin
        if (full_tick) begin
          cnt_d = '0;
          sr_en = 1'b1;
          if (bit_q == BIT_LAST) state_d = RX_STOP;
          else                   bit_d   = bit_q + 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      RX_STOP: begin
        if (full_tick) begin
          cnt_d = '0;
          if (rx_i) begin
            vld_d   = 1'b1;
            state_d = RX_IDLE;
          end else begin
            state_d = RX_BREAK;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      RX_BREAK: begin
        cnt_d = '0;
        if (rx_i) state_d = RX_IDLE;
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      vld_q   <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= {rx_i, sr_q[DATA_BITS-1:1]};
  end

  assign byte_vld_o = vld_q;
  assign byte_o     = sr_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL) else $error("bit counter overran"); // R2
  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_o |=> !byte_vld_o) else $error("byte valid longer than one cycle"); // R2
  AST_START_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_START && half_tick && rx_i) |=> (state_q == RX_IDLE && !byte_vld_o))
    else $error("false start accepted"); // R3
  AST_FRAME_ERR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_STOP && full_tick && !rx_i) |=> (!byte_vld_o && state_q == RX_BREAK))
    else $error("bad stop bit not discarded"); // R8

endmodule

// File: rtl/synth_cmd_decode.sv
module synth_cmd_decode
  import synth_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  output logic [1:0] wave_o,
  output logic [3:0] freq_o,
  output logic       noise_o,
  output logic       stb_o
);

  wave_e       wave_q, wave_d;
  logic [3:0]  freq_q, freq_d;
  logic        noise_q, noise_d;
  logic        hit;
  logic        stb_q;
  logic        is_digit;
  logic [7:0]  digit_off;

  assign is_digit  = (byte_i >= CH_DIG_LO) && (byte_i <= CH_DIG_HI);
  assign digit_off = byte_i - CH_DIG_LO;

  always_comb begin
    wave_d  = wave_q;
    freq_d  = freq_q;
    noise_d = noise_q;
    hit     = 1'b0;
    if (byte_vld_i) begin
      if (is_digit) begin
        freq_d = digit_off[3:0];
        hit    = 1'b1;
      end else begin
        case (byte_i)
          CH_TRI:    begin wave_d  = WAVE_TRI;    hit = 1'b1; end
          CH_SAW:    begin wave_d  = WAVE_SAW;    hit = 1'b1; end
          CH_SQUARE: begin wave_d  = WAVE_SQUARE; hit = 1'b1; end
          CH_SINE:   begin wave_d  = WAVE_SINE;   hit = 1'b1; end
          CH_NOISE1: begin noise_d = 1'b1;        hit = 1'b1; end
          CH_NOISE0: begin noise_d = 1'b0;        hit = 1'b1; end
          default:   hit = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wave_q  <= WAVE_SQUARE;
      freq_q  <= '0;
      noise_q <= 1'b0;
    end else if (hit) begin
      wave_q  <= wave_d;
      freq_q  <= freq_d;
      noise_q <= noise_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= hit;
  end

  assign wave_o  = wave_q;
  assign freq_o  = freq_q;
  assign noise_o = noise_q;
  assign stb_o   = stb_q;

  AST_FREQ_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    freq_o <= 4'd9) else $error("pitch index out of range"); // R5
  AST_NOISE_KEEPS_WAVE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(noise_o) |-> ($stable(wave_o) && $stable(freq_o)))
    else $error("noise command moved other settings"); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld_i |=> ($stable(wave_o) && $stable(freq_o) && $stable(noise_o)))
    else $error("setting changed with no character"); // R7
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o |=> !stb_o) else $error("strobe wider than one cycle"); // R9
  AST_CHANGE_HAS_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(wave_o) || !$stable(freq_o) || !$stable(noise_o)) |-> stb_o)
    else $error("setting changed without strobe"); // R9

endmodule

// File: rtl/synth_cmd_uart.sv
module synth_cmd_uart #(
  parameter int CLKS_PER_BIT = 65,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_i,
  output logic [1:0] wave_sel_o,
  output logic [3:0] freq_idx_o,
  output logic       noise_en_o,
  output logic       cmd_stb_o
);

  localparam int DATA_BITS = 8;

  logic                 rx_sync;
  logic                 byte_vld;
  logic [DATA_BITS-1:0] byte_val;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (rx_i),
    .q_o   (rx_sync)
  );

  uart_rx_frame #(
    .CLKS_PER_BIT (CLKS_PER_BIT),
    .DATA_BITS    (DATA_BITS)
  ) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_i       (rx_sync),
    .byte_vld_o (byte_vld),
    .byte_o     (byte_val)
  );

  synth_cmd_decode u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_vld_i (byte_vld),
    .byte_i     (byte_val),
    .wave_o     (wave_sel_o),
    .freq_o     (freq_idx_o),
    .noise_o    (noise_en_o),
    .stb_o      (cmd_stb_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) $rose(rst_n) |->
    (wave_sel_o == 2'b00 && freq_idx_o == 4'd0 && !noise_en_o && !cmd_stb_o))
    else $error("outputs not at reset values"); // R1

endmodule

// File: tb/synth_cmd_uart_bench.sv
`timescale 1ns / 1ps
module synth_cmd_uart_bench;

  localparam int CPB = 8;

  logic       clk;
  logic       rst_n;
  logic       rx;
  logic [1:0] wave;
  logic [3:0] freq;
  logic       noise;
  logic       stb;

  int n_checks = 0;
  int n_fail   = 0;
  int stb_count = 0;
  int stb_run   = 0;
  int stb_maxrun = 0;
  int silent_change = 0;
  logic [6:0] prev_out;

  int exp_wave = 0;
  int exp_freq = 0;
  int exp_noise = 0;

  synth_cmd_uart #(.CLKS_PER_BIT(CPB)) u_synth_cmd_uart (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_i       (rx),
    .wave_sel_o (wave),
    .freq_idx_o (freq),
    .noise_en_o (noise),
    .cmd_stb_o  (stb)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (stb) begin
        stb_count++;
        stb_run++;
        if (stb_run > stb_maxrun) stb_maxrun = stb_run;
      end else begin
        stb_run = 0;
      end
      if ({wave, freq, noise} !== prev_out && !stb) silent_change++;
    end
    prev_out = {wave, freq, noise};
  end

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    stb_count = 0;
    stb_maxrun = 0;
    silent_change = 0;
  endtask

  task automatic send(input logic [7:0] b, input logic stop_lvl, input int stop_bits);
    @(negedge clk);
    rx = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      repeat (CPB) @(negedge clk);
    end
    rx = stop_lvl;
    repeat (CPB * stop_bits) @(negedge clk);
    rx = 1'b1;
    repeat (CPB * 3) @(negedge clk);
  endtask

  function automatic int is_cmd(input logic [7:0] b);
    return (b == 8'h54 || b == 8'h53 || b == 8'h51 || b == 8'h57 ||
            b == 8'h4E || b == 8'h46 || (b >= 8'h30 && b <= 8'h39)) ? 1 : 0;
  endfunction

  task automatic model(input logic [7:0] b);
    case (b)
      8'h54: exp_wave = 1;
      8'h53: exp_wave = 2;
      8'h51: exp_wave = 0;
      8'h57: exp_wave = 3;
      8'h4E: exp_noise = 1;
      8'h46: exp_noise = 0;
      default: if (b >= 8'h30 && b <= 8'h39) exp_freq = int'(b) - 48;
    endcase
  endtask

  task automatic check_state(input string req);
    chk({req, " wave"},  int'(wave),  exp_wave);
    chk({req, " freq"},  int'(freq),  exp_freq);
    chk({req, " noise"}, int'(noise), exp_noise);
  endtask

  task automatic good_byte(input logic [7:0] b, input string req);
    clear_mon();
    send(b, 1'b1, 1);
    model(b);
    check_state(req);
    chk({req, " strobe count R9"}, stb_count, is_cmd(b));
    chk({req, " silent change R9"}, silent_change, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rx = 1'b1;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    // R1: values under reset
    chk("R1 wave in reset", int'(wave), 0);
    chk("R1 freq in reset", int'(freq), 0);
    chk("R1 noise in reset", int'(noise), 0);
    chk("R1 strobe in reset", int'(stb), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_state("R1 after reset");
    chk("R1 strobe after reset", int'(stb), 0);

    // R4 R5 R6: distinct commands from a non-default state
    good_byte(8'h57, "R4 sine");
    good_byte(8'h37, "R5 digit 7");
    good_byte(8'h4E, "R6 noise on");
    good_byte(8'h54, "R6 wave kept then R4 tri");
    // R9: repeat of the same command still strobes once
    good_byte(8'h54, "R9 repeat tri");

    // R3: short low glitch does nothing
    clear_mon();
    @(negedge clk);
    rx = 1'b0;
    repeat (CPB / 2 - 2) @(negedge clk);
    rx = 1'b1;
    repeat (CPB * 12) @(negedge clk);
    check_state("R3 glitch");
    chk("R3 glitch strobe", stb_count, 0);

    // R8: low stop bit discards a command, then recovery
    clear_mon();
    send(8'h53, 1'b0, 1);
    check_state("R8 bad stop");
    chk("R8 bad stop strobe", stb_count, 0);
    clear_mon();
    send(8'h46, 1'b0, 3);
    check_state("R8 long break");
    chk("R8 long break strobe", stb_count, 0);
    good_byte(8'h53, "R8 recovery saw");

    // R2 R7: sweep of every character value
    for (int v = 0; v < 256; v++) begin
      good_byte(8'(v), is_cmd(8'(v)) ? "R2 sweep command" : "R7 sweep ignored");
    end

    chk("R9 max strobe run", stb_maxrun <= 1 ? 1 : 0, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule